// File: doc/BRIEF.md
# Selectable Diagnostic Pattern Generator

This block is a built-in source of known test data that sits in front of a processing unit's real-time output. While a host-held enable is low, it passes the unit's normal result words straight through. While the enable is high, it replaces them with a stream of events, one event per clock, taken from a fixed menu of patterns chosen by a 3-bit select. Each output line carries one bit per event, so the stream suits a serial link running at 160 Mb/s per line.

The stream repeats every 256 events. It starts with one marker event, flagged by a sync output, and continues with 255 pattern events. The menu includes static levels, a clock-like toggle, a walking one, a crosstalk pattern that drives neighbouring lines to opposite values, intersymbol-interference patterns made of long runs broken by a single-event transition, and an index count. A receiver uses the marker to find event boundaries during its timing calibration. It then uses the stress patterns to check its sampling margin.

The block is kept in the production design at all times and can be used for any processing unit, because the line count is a parameter. A select change takes effect only at a marker event, so every 256-event cycle is made of a single pattern.

Top module: `diag_pattern_gen`

## Requirements
- R1: While `rst` is sampled high, the next outputs are `out_data` = 0 and `out_sync` = 0. Reset is synchronous and active high.
- R2: While `cfg_enable` is sampled low, the output one clock later equals the `func_data` value sampled at that edge, with `out_sync` = 0.
- R3: At the first edge with `cfg_enable` sampled high after it was low or after reset, the block emits event index 0, the marker. In the marker, line b is 1 exactly when bit 1 of b is set (0xCCCC for 16 lines), and `out_sync` = 1.
- R4: While enabled, the event index advances by one every clock from 0 to 255 and wraps to 0. `out_sync` is 1 only on index 0, so it is high for one clock in every 256.
- R5: `cfg_select` is sampled only at the edge that emits index 0. Events 1 to 255 use that latched value, and changes at any other time have no effect until the next marker.
- R6: For events i = 1..255: select 0 gives all lines 0, select 1 gives all lines 1, and select 2 gives all lines equal to bit 0 of i.
- R7: Select 3 (walking one) sets only line (i-1) mod LINES.
- R8: Select 4 (crosstalk) drives even-numbered lines to bit 0 of i and odd-numbered lines to its inverse. For 16 lines this gives 0x5555 for odd i and 0xAAAA for even i.
- R9: Select 5 (ISI, low run) gives all lines 1 when the low RUN_W bits of i are all ones and 0 otherwise. Select 7 (ISI, high run) is its inverse. With RUN_W = 4 the transition falls at i = 15, 31, and so on up to 255.
- R10: Select 6 (count) drives line b to bit (b mod 8) of i.
- R11: Dropping `cfg_enable` for one clock in mid-cycle restarts the sequence. The next enabled event is the marker, followed by index 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one event per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Host enable: 1 selects pattern output, 0 selects pass-through |
| cfg_select | input | 3 | Pattern menu index, latched at the marker event |
| func_data | input | LINES | Normal result words from the processing unit |
| out_data | output | LINES | Registered output word, one bit per line |
| out_sync | output | 1 | High on the marker event of each 256-event cycle |

## Verification
The hardest condition to reach is a select change partway through a cycle. It must not show up in the output for the rest of that cycle, but it must be in force right after the next marker. The stimulus enables the crosstalk pattern, switches the select to all-ones at event 10, and then compares every event through the wrap at 256 and beyond. A mid-cycle enable drop is also exercised, to show that the index restarts at the marker rather than resuming where it stopped.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  localparam int EVT_W = 8;

  typedef enum logic [2:0] {
    PAT_ZEROS  = 3'd0,
    PAT_ONES   = 3'd1,
    PAT_TOGGLE = 3'd2,
    PAT_WALK   = 3'd3,
    PAT_XTALK  = 3'd4,
    PAT_ISI_LO = 3'd5,
    PAT_COUNT  = 3'd6,
    PAT_ISI_HI = 3'd7
  } pat_e;

  // value of one line for a given pattern and event index
  function automatic logic line_value(pat_e sel, logic [EVT_W-1:0] idx,
                                      int unsigned lane, int unsigned nlanes,
                                      logic [EVT_W-1:0] run_mask);
    logic [EVT_W-1:0] walk_pos;
    logic             res;
    walk_pos = EVT_W'((32'(idx) - 32'd1) % nlanes);
    if (idx == '0) begin
      res = ((lane >> 1) & 1) == 1;
    end else begin
      unique case (sel)
        PAT_ZEROS:  res = 1'b0;
        PAT_ONES:   res = 1'b1;
        PAT_TOGGLE: res = idx[0];
        PAT_WALK:   res = (32'(walk_pos) == lane);
        PAT_XTALK:  res = (lane % 2 == 0) ? idx[0] : ~idx[0];
        PAT_ISI_LO: res = ((idx & run_mask) == run_mask);
        PAT_COUNT:  res = idx[lane % EVT_W];
        PAT_ISI_HI: res = ((idx & run_mask) != run_mask);
        default:    res = 1'b0;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/dpg_sequencer.sv
module dpg_sequencer
  import dpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  pat_e             sel_in,
  output logic [EVT_W-1:0] idx,
  output pat_e             eff_sel,
  output logic             at_marker
);

  logic [EVT_W-1:0] cnt;
  pat_e             held_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      held_sel <= PAT_ZEROS;
    end else if (!enable) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + EVT_W'(1);
      if (cnt == '0) held_sel <= sel_in;
    end
  end

  assign idx       = cnt;
  assign at_marker = (cnt == '0);
  assign eff_sel   = at_marker ? sel_in : held_sel;

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && cnt == '1) |=> (cnt == '0));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(held_sel));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0));

endmodule

// File: rtl/dpg_pattern_core.sv
module dpg_pattern_core
  import dpg_pkg::*;
#(
  parameter int LINES = 16,
  parameter int RUN_W = 4
) (
  input  pat_e             sel,
  input  logic [EVT_W-1:0] idx,
  output logic [LINES-1:0] word
);

  localparam logic [EVT_W-1:0] RUN_MASK = EVT_W'((1 << RUN_W) - 1);

  for (genvar b = 0; b < LINES; b++) begin : g_line
    assign word[b] = line_value(sel, idx, b, LINES, RUN_MASK);
  end

endmodule

// File: rtl/dpg_out_stage.sv
module dpg_out_stage #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_pattern,
  input  logic             marker,
  input  logic [LINES-1:0] pat_word,
  input  logic [LINES-1:0] func_word,
  output logic [LINES-1:0] q_data,
  output logic             q_sync
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_data <= '0;
      q_sync <= 1'b0;
    end else begin
      q_data <= use_pattern ? pat_word : func_word;
      q_sync <= use_pattern & marker;
    end
  end

endmodule

// File: rtl/diag_pattern_gen.sv
module diag_pattern_gen
  import dpg_pkg::*;
#(
  parameter int LINES = 16,
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic [2:0]       cfg_select,
  input  logic [LINES-1:0] func_data,
  output logic [LINES-1:0] out_data,
  output logic             out_sync
);

  logic [EVT_W-1:0] idx;
  pat_e             eff_sel;
  logic             at_marker;
  logic [LINES-1:0] pat_word;

  dpg_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (cfg_enable),
    .sel_in    (pat_e'(cfg_select)),
    .idx       (idx),
    .eff_sel   (eff_sel),
    .at_marker (at_marker)
  );

  dpg_pattern_core #(.LINES(LINES), .RUN_W(RUN_W)) u_core (
    .sel  (eff_sel),
    .idx  (idx),
    .word (pat_word)
  );

  dpg_out_stage #(.LINES(LINES)) u_out (
    .clk         (clk),
    .rst         (rst),
    .use_pattern (cfg_enable),
    .marker      (at_marker),
    .pat_word    (pat_word),
    .func_word   (func_data),
    .q_data      (out_data),
    .q_sync      (out_sync)
  );

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> (out_data == $past(func_data)) && !out_sync);

  // R4
  sync_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_sync |=> !out_sync);

  // R3
  sync_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_sync) |-> $past(cfg_enable));

endmodule

// File: tb/sim_diag_pattern_gen.sv
module sim_diag_pattern_gen;
  localparam int L = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         en;
  logic [2:0]   sel;
  logic [L-1:0] fd;
  logic [L-1:0] out_data;
  logic         out_sync;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  diag_pattern_gen #(.LINES(L), .RUN_W(4)) u0 (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_select(sel),
    .func_data(fd), .out_data(out_data), .out_sync(out_sync)
  );

  function automatic logic [L-1:0] model(int s, int i);
    logic [L-1:0] w;
    w = '0;
    for (int b = 0; b < L; b++) begin
      if (i == 0) w[b] = (b % 4) >= 2;
      else case (s)
        0: w[b] = 1'b0;
        1: w[b] = 1'b1;
        2: w[b] = (i % 2) == 1;
        3: w[b] = ((i - 1) % L) == b;
        4: w[b] = (b % 2 == 0) ? ((i % 2) == 1) : ((i % 2) == 0);
        5: w[b] = (i % 16) == 15;
        6: w[b] = ((i >> (b % 8)) & 1) == 1;
        7: w[b] = (i % 16) != 15;
        default: w[b] = 1'b0;
      endcase
    end
    return w;
  endfunction

  function automatic string req_of(int s);
    case (s)
      0, 1, 2: return "R6";
      3:       return "R7";
      4:       return "R8";
      6:       return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_word(string req, logic [L-1:0] a, logic [L-1:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s out_data actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic chk_sync(string req, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s out_sync actual=%b expected=%b", req, a, e);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1; en = 1'b0; sel = 3'd0; fd = '1;
    tick; tick; tick;
    chk_word("R1", out_data, '0);
    chk_sync("R1", out_sync, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_bypass;
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      fd = L'(k * 16'h1111) ^ L'(16'h0F0F);
      tick;
      chk_word("R2", out_data, fd);
      chk_sync("R2", out_sync, 1'b0);
    end
  endtask

  task automatic t_pattern(int s);
    en = 1'b0; tick;
    sel = 3'(s); en = 1'b1;
    for (int i = 0; i < 258; i++) begin
      fd = L'(i * 37);
      tick;
      chk_word((i % 256 == 0) ? "R3" : req_of(s), out_data, model(s, i % 256));
      chk_sync("R4", out_sync, (i % 256) == 0);
    end
  endtask

  task automatic t_select_change;
    en = 1'b0; tick;
    sel = 3'd4; en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      tick;
      chk_word("R5", out_data, model(i < 256 ? 4 : 1, i % 256));
      chk_sync("R5", out_sync, (i % 256) == 0);
      if (i == 10) sel = 3'd1;
    end
  endtask

  task automatic t_reenable;
    en = 1'b0; tick;
    sel = 3'd3; en = 1'b1;
    for (int i = 0; i < 50; i++) begin
      tick;
      chk_word("R7", out_data, model(3, i));
    end
    en = 1'b0; fd = 16'hBEEF;
    tick;
    chk_word("R11", out_data, 16'hBEEF);
    chk_sync("R11", out_sync, 1'b0);
    en = 1'b1;
    tick;
    chk_word("R11", out_data, model(3, 0));
    chk_sync("R11", out_sync, 1'b1);
    tick;
    chk_word("R11", out_data, model(3, 1));
    chk_sync("R11", out_sync, 1'b0);
    rst = 1'b1;
    tick;
    chk_word("R1", out_data, '0);
    chk_sync("R1", out_sync, 1'b0);
    rst = 1'b0; en = 1'b0;
    tick;
  endtask

  initial begin
    t_reset;
    t_bypass;
    for (int s = 0; s < 8; s++) t_pattern(s);
    t_select_change;
    t_reenable;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule